// File: doc/BRIEF.md
# Coin-Accumulating Vend Controller

This block totals the value of coins dropped into a vending slot and raises a single-cycle vend pulse once the running sum meets or exceeds the current price. Each coin is announced by a one-cycle presence strobe and a coin value. The price is a separate input that the host keeps steady while a purchase is in progress. After each vend the running sum is cleared and the next purchase starts from zero. The block does not give change and does not validate coins.

The design is split into a datapath and a controller. The datapath holds the running-sum register, a wrap-around adder and an unsigned less-than comparator. The controller is a four-state machine. It drives only two single-bit controls into the datapath, load and clear, and reads back only the single comparison bit. It never sees the multi-bit values directly.

The controller's states are Init, Wait, Add and Vend. The bench expects them in that order after reset. A coin takes two cycles to absorb: one cycle in Wait that sees the strobe, then one cycle in Add that loads the sum.

Top module: `coin_vend_top`

## Requirements
- R1: While `rst_n` is low, `vend_o` is 0 and the controller is held in Init. The first clock edge after release performs the Init action, and the controller is in Wait after that edge.
- R2: Init clears the running sum, keeps `vend_o` at 0, and always moves to Wait at the next edge.
- R3: In Wait, `coin_i`=1 moves the controller to Add at the next edge. This holds whatever the running sum is, so a coin takes priority over a vend.
- R4: In Add, the running sum is loaded with the sum plus the `coin_val_i` present in the Add cycle. The controller then returns to Wait.
- R5: In Wait with `coin_i`=0 and an unsigned running sum below `price_i`, the controller stays in Wait and `vend_o` stays 0.
- R6: In Wait with `coin_i`=0 and an unsigned running sum greater than or equal to `price_i`, the controller enters Vend at the next edge. `vend_o` is then 1 for exactly one cycle.
- R7: Vend is always followed by Init, so a purchase after a vend starts from a sum of 0.
- R8: The running sum changes only at a rising edge where load or clear is active. When both are active, clear wins.
- R9: The addition wraps modulo 2^W. For example, with W=4, a sum of 12 plus a coin of 6 gives 2.
- R10: `coin_val_i` has no effect outside the Add cycle. `price_i` is only consulted in Wait.
- R11: Load is active only in Add and clear only in Init. The two are never active in the same cycle, and neither is active in Wait or Vend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| coin_i | input | 1 | Coin presence strobe, high for one cycle per coin |
| coin_val_i | input | W | Value of the coin, held through the Add cycle |
| price_i | input | W | Unsigned price of one item |
| vend_o | output | 1 | One-cycle vend pulse |

## Verification
Several properties are checked on every cycle:
- load and clear are mutually exclusive;
- the running sum is held whenever neither control is active;
- a load produces exactly the wrapped sum;
- a clear produces zero;
- a coin strobe seen in Wait always leads to Add;
- a sufficient sum with no coin always leads to a single vend pulse followed by Init.

Only the bench scenarios can show the end-to-end purchase arithmetic. These include an exhaustive sweep of prices against first coins, at the exact boundary where the sum equals the price, through a wrap-around, after a reset in the middle of a purchase, and with the coin value changing on idle cycles.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADD  = 2'd2,
    ST_VEND = 2'd3
  } vend_state_e;

  typedef struct packed {
    logic ld;
    logic clr;
  } sum_ctrl_t;

endpackage

// File: rtl/coin_vend_sum_reg.sv
module coin_vend_sum_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // Clear has priority over load; otherwise the register holds.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (clr_i) begin
      q_o <= '0;
    end else if (ld_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/coin_vend_dp.sv
module coin_vend_dp
  import coin_vend_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sum_ctrl_t    ctrl_i,
  input  logic [W-1:0] coin_val_i,
  input  logic [W-1:0] price_i,
  output logic [W-1:0] sum_o,
  output logic         below_o
);

  logic [W-1:0] sum_q;
  logic [W-1:0] sum_next;

  // Wrap-around adder: the carry out of the top bit is dropped.
  always_comb begin
    sum_next = sum_q + coin_val_i;
  end

  coin_vend_sum_reg #(.W(W)) u_sum_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ctrl_i.clr),
    .ld_i  (ctrl_i.ld),
    .d_i   (sum_next),
    .q_o   (sum_q)
  );

  // Unsigned comparison on the registered sum only.
  always_comb begin
    below_o = (sum_q < price_i);
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      coin_i,
  input  logic      below_i,
  output sum_ctrl_t ctrl_o,
  output logic      vend_o
);

  vend_state_e state_q;
  vend_state_e state_d;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT: state_d = ST_WAIT;
      ST_WAIT: begin
        if (coin_i) begin
          state_d = ST_ADD;
        end else if (!below_i) begin
          state_d = ST_VEND;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_ADD:  state_d = ST_WAIT;
      ST_VEND: state_d = ST_INIT;
      default: state_d = ST_INIT;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
    end else begin
      state_q <= state_d;
    end
  end

  // Moore outputs: every control defaults to 0.
  always_comb begin
    ctrl_o.ld  = 1'b0;
    ctrl_o.clr = 1'b0;
    vend_o     = 1'b0;
    unique case (state_q)
      ST_INIT: ctrl_o.clr = 1'b1;
      ST_ADD:  ctrl_o.ld  = 1'b1;
      ST_VEND: vend_o     = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/coin_vend_top.sv
module coin_vend_top
  import coin_vend_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         coin_i,
  input  logic [W-1:0] coin_val_i,
  input  logic [W-1:0] price_i,
  output logic         vend_o
);

  sum_ctrl_t    sum_ctrl;
  logic         tot_ld;
  logic         tot_clr;
  logic         tot_below;
  logic [W-1:0] total;

  coin_vend_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .coin_i  (coin_i),
    .below_i (tot_below),
    .ctrl_o  (sum_ctrl),
    .vend_o  (vend_o)
  );

  coin_vend_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_i     (sum_ctrl),
    .coin_val_i (coin_val_i),
    .price_i    (price_i),
    .sum_o      (total),
    .below_o    (tot_below)
  );

  assign tot_ld  = sum_ctrl.ld;
  assign tot_clr = sum_ctrl.clr;

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         coin_i,
  input logic [W-1:0] coin_val_i,
  input logic [W-1:0] price_i,
  input logic         vend_o,
  input logic         tot_ld,
  input logic         tot_clr,
  input logic [W-1:0] total
);

  logic         in_wait;
  logic [W-1:0] sum_w;

  assign in_wait = !vend_o && !tot_ld && !tot_clr;
  assign sum_w   = total + coin_val_i;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !vend_o);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tot_clr |=> (total == '0));

  p_coin_to_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && coin_i) |=> tot_ld);

  p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tot_ld |=> (total == $past(sum_w)));

  p_add_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tot_ld |=> (!tot_ld && !tot_clr && !vend_o));

  p_wait_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !coin_i && (total < price_i)) |=> in_wait);

  p_wait_enough_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !coin_i && (total >= price_i)) |=> vend_o);

  p_vend_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vend_o |=> !vend_o);

  p_vend_then_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vend_o |=> tot_clr);

  p_sum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tot_ld && !tot_clr) |=> $stable(total));

  p_ctrl_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tot_ld && tot_clr) && $countones({tot_ld, tot_clr, vend_o}) <= 1);

endmodule

bind coin_vend_top coin_vend_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .coin_i     (coin_i),
  .coin_val_i (coin_val_i),
  .price_i    (price_i),
  .vend_o     (vend_o),
  .tot_ld     (tot_ld),
  .tot_clr    (tot_clr),
  .total      (total)
);

// File: tb/coin_vend_top_tb_top.sv
module coin_vend_top_tb_top;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         coin_i;
  logic [W-1:0] coin_val_i;
  logic [W-1:0] price_i;
  logic         vend_o;

  int checks;
  int failures;
  logic [W-1:0] tot_m;
  logic [W-1:0] price_m;

  coin_vend_top #(.W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .coin_i     (coin_i),
    .coin_val_i (coin_val_i),
    .price_i    (price_i),
    .vend_o     (vend_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: vend_o=%0b expected %0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_price(input logic [W-1:0] p);
    price_i = p;
    price_m = p;
  endtask

  // Called at a falling edge while the controller is in Wait.
  task automatic put_coin(input logic [W-1:0] v);
    coin_i     = 1'b1;
    coin_val_i = v;
    @(negedge clk);
    chk("R3/R11 coin in Wait goes to Add without vend", vend_o, 1'b0);
    coin_i = 1'b0;
    @(negedge clk);
    coin_val_i = ~v;  // R10: value changes outside Add must not matter
    tot_m = tot_m + v;
  endtask

  task automatic idle(input string req);
    logic e;
    e = (tot_m >= price_m);
    coin_i = 1'b0;
    @(negedge clk);
    chk(req, vend_o, e);
    if (e) begin
      @(negedge clk);
      chk("R6/R7 vend pulse one cycle then Init", vend_o, 1'b0);
      @(negedge clk);
      tot_m = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    coin_i = 1'b0;
    @(negedge clk);
    chk("R1 vend low in reset", vend_o, 1'b0);
    @(negedge clk);
    chk("R1 vend low in reset", vend_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 Init after release gives no vend", vend_o, 1'b0);
    tot_m = '0;
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    coin_i = 1'b0;
    coin_val_i = '0;
    price_i = '0;
    price_m = '0;
    tot_m = '0;
    do_reset();

    // Price 0: a sum of 0 already suffices.
    set_price(4'd0);
    idle("R6 price 0 vends at once");

    // R3: a coin wins over a sufficient sum.
    set_price(4'd2);
    put_coin(4'd5);
    put_coin(4'd0);
    idle("R3 vend only after coin strobe ends");

    // R9: wrap-around of the sum.
    set_price(4'd15);
    put_coin(4'd12);
    idle("R5 12 below 15");
    put_coin(4'd6);
    idle("R9 12+6 wraps to 2, no vend");
    put_coin(4'd13);
    idle("R9 2+13 reaches 15, vend");

    // R5/R8/R10: holding in Wait with a changing coin value.
    set_price(4'd9);
    put_coin(4'd4);
    for (int k = 0; k < 4; k++) begin
      coin_val_i = 4'(k * 5 + 3);
      idle("R8/R10 sum held while idle");
    end
    put_coin(4'd5);
    idle("R4 4+5 equals price 9");

    // R7: next purchase starts from zero.
    set_price(4'd3);
    put_coin(4'd3);
    idle("R6 sum equals price");
    idle("R7 sum cleared after vend");
    put_coin(4'd3);
    idle("R7 fresh purchase vends");

    // R1: reset in the middle of a purchase clears the sum.
    set_price(4'd9);
    put_coin(4'd8);
    do_reset();
    set_price(4'd8);
    idle("R1 sum cleared by reset");
    put_coin(4'd8);
    idle("R1 purchase after reset");

    // Exhaustive sweep of price against first coin.
    for (int p = 0; p < N; p++) begin
      for (int v = 0; v < N; v++) begin
        set_price(W'(p));
        put_coin(W'(v));
        idle("R5/R6 first coin compared with price");
        if (tot_m != '0) begin
          put_coin(W'(p - v));
          idle("R4/R6 topped up to price");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule